// File: doc/BRIEF.md
# Multi-Format Integer Multiply Unit

This block is the multiply engine of the execute stage in a 32-bit core. One iterative datapath serves seven operation codes. It forms full-word products, signed or unsigned, that are 64 bits wide. It also forms signed halfword products that are 32 bits wide. The operand that is not a register comes either from a second register, from a short immediate or from a 16-bit immediate. A formatting stage picks that operand by the operation code.

The pipeline raises `start_i` for one cycle with the operation code, both register values and the immediate field. The unit takes the request only when it is idle. It retires a number of multiplier bits in each cycle. It then presents the result with a one-cycle `done_o`. In the word forms it also raises `hi_we_o`, so that the high word is written to the second destination. The results stay on the outputs until the next completion. The unit has no flag outputs, so a multiply never changes the condition state.

Top module: `mpy_unit`

## Requirements
- R1: Code 0 (word signed, register): the signed 64-bit product src_b_i × src_a_i appears with low half on res_lo_o and high half on res_hi_o; hi_we_o is high only together with done_o.
- R2: Code 1 (word signed, immediate): src_b_i is multiplied signed by imm_i[8:0] sign-extended to 32 bits, giving a 64-bit product and hi_we_o.
- R3: Code 2 (word unsigned, register): the unsigned 64-bit product src_b_i × src_a_i, with hi_we_o.
- R4: Code 3 (word unsigned, immediate): imm_i[8:0] is first sign-extended to 32 bits and then used as an unsigned operand against src_b_i (so 9'h1FF acts as 32'hFFFFFFFF), with hi_we_o.
- R5: Code 4 (halfword, register): signed src_b_i[15:0] × src_a_i[15:0] gives a 32-bit result on res_lo_o; res_hi_o is zero and hi_we_o stays low; bits [31:16] of the sources are ignored.
- R6: Code 5 (halfword, short immediate): signed src_b_i[15:0] × imm_i[4:0] sign-extended, as in R5 for res_hi_o and hi_we_o.
- R7: Code 6 (halfword, 16-bit immediate): signed src_a_i[15:0] × signed imm_i[15:0]; src_b_i is ignored, and the rule of R5 holds for res_hi_o and hi_we_o.
- R8: done_o is a single-cycle pulse. It rises exactly WORD_W/BITS_PER_STEP cycles after the clock edge that accepted start_i. Between completions the result outputs hold their values.
- R9: start_i is ignored while an operation is in progress, so the running result and its timing are unchanged. A start in the done cycle is accepted.
- R10: Code 7 is reserved. It completes with the normal timing, with both result words zero and hi_we_o low.
- R11: After reset, done_o and hi_we_o are low and both result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 3 | Operation code 0..7 (see R1-style codes in requirements) |
| src_a_i | input | 32 | First source register value |
| src_b_i | input | 32 | Second source register value |
| imm_i | input | 16 | Immediate field from the instruction |
| res_lo_o | output | 32 | Low result word, primary destination |
| res_hi_o | output | 32 | High result word, secondary destination |
| hi_we_o | output | 1 | Write enable for the secondary destination |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the unit with BITS_PER_STEP set to 4, so each operation takes eight cycles instead of the default sixteen. With the shorter run, a held start, which causes back-to-back restarts in the done cycle, fits into a short test, as do start pulses during a run. A wider digit also puts larger partial products into every step, and operands such as 32'h80000000 and all-ones exercise the carries between steps. The bench also varies the upper bits of the source registers in halfword modes, to show that those bits have no effect on the result.

// File: rtl/mpy_pkg.sv
`timescale 1ns/1ps
package mpy_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int IMM_W  = 16;
  localparam int SIMM_W = 9;
  localparam int TINY_W = 5;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    MOP_WORD_S    = 3'd0,
    MOP_WORD_SI   = 3'd1,
    MOP_WORD_U    = 3'd2,
    MOP_WORD_UI   = 3'd3,
    MOP_HALF_R    = 3'd4,
    MOP_HALF_I5   = 3'd5,
    MOP_HALF_I16  = 3'd6,
    MOP_RESERVED  = 3'd7
  } mpy_op_e;

  // 9-bit immediate widened to a word, keeping its sign
  function automatic logic [WORD_W-1:0] widen_simm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
  endfunction

  // 5-bit immediate widened to a halfword, keeping its sign
  function automatic logic [HALF_W-1:0] widen_tiny(input logic [IMM_W-1:0] imm);
    return {{(HALF_W-TINY_W){imm[TINY_W-1]}}, imm[TINY_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] widen_half(input logic [HALF_W-1:0] h);
    return {{(WORD_W-HALF_W){h[HALF_W-1]}}, h};
  endfunction

  function automatic logic writes_high(input mpy_op_e op);
    return (op == MOP_WORD_S) || (op == MOP_WORD_SI) ||
           (op == MOP_WORD_U) || (op == MOP_WORD_UI);
  endfunction

  // Magnitude of a word, seen as signed when sgn is set
  function automatic logic [WORD_W-1:0] magnitude(input logic [WORD_W-1:0] v, input logic sgn);
    return (sgn && v[WORD_W-1]) ? (~v + 1'b1) : v;
  endfunction
endpackage

// File: rtl/mpy_opfmt.sv
`timescale 1ns/1ps
module mpy_opfmt
  import mpy_pkg::*;
(
  input  mpy_op_e            op_i,
  input  logic [WORD_W-1:0]  src_a_i,
  input  logic [WORD_W-1:0]  src_b_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic [WORD_W-1:0]  opa_o,
  output logic [WORD_W-1:0]  opb_o,
  output logic               signed_o,
  output logic               wide_o
);
  always_comb begin
    opa_o    = '0;
    opb_o    = '0;
    signed_o = 1'b0;
    wide_o   = writes_high(op_i);
    unique case (op_i)
      MOP_WORD_S:   begin opa_o = src_b_i; opb_o = src_a_i;         signed_o = 1'b1; end
      MOP_WORD_SI:  begin opa_o = src_b_i; opb_o = widen_simm(imm_i); signed_o = 1'b1; end
      MOP_WORD_U:   begin opa_o = src_b_i; opb_o = src_a_i;         end
      MOP_WORD_UI:  begin opa_o = src_b_i; opb_o = widen_simm(imm_i); end
      MOP_HALF_R: begin
        opa_o = widen_half(src_b_i[HALF_W-1:0]);
        opb_o = widen_half(src_a_i[HALF_W-1:0]);
        signed_o = 1'b1;
      end
      MOP_HALF_I5: begin
        opa_o = widen_half(src_b_i[HALF_W-1:0]);
        opb_o = widen_half(widen_tiny(imm_i));
        signed_o = 1'b1;
      end
      MOP_HALF_I16: begin
        opa_o = widen_half(src_a_i[HALF_W-1:0]);
        opb_o = widen_half(imm_i[HALF_W-1:0]);
        signed_o = 1'b1;
      end
      default: begin end
    endcase
  end
endmodule

// File: rtl/mpy_core.sv
`timescale 1ns/1ps
module mpy_core
  import mpy_pkg::*;
#(
  parameter int BITS_PER_STEP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [WORD_W-1:0]    opa_i,
  input  logic [WORD_W-1:0]    opb_i,
  input  logic                 signed_i,
  input  logic                 wide_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 wide_o,
  output logic [2*WORD_W-1:0]  prod_o
);
  localparam int STEPS  = WORD_W / BITS_PER_STEP;
  localparam int CNT_W  = $clog2(STEPS + 1);
  localparam int PROD_W = 2 * WORD_W;

  logic               busy_q, done_q, neg_q, wide_run_q, wide_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PROD_W-1:0]  acc_q, mcand_q, prod_q;
  logic [WORD_W-1:0]  mplier_q;

  // named events for the assertions
  logic               accept_w, last_step_w;
  logic [PROD_W-1:0]  acc_nxt_w;

  assign accept_w    = load_i && !busy_q;
  assign last_step_w = busy_q && (cnt_q == CNT_W'(1));
  assign acc_nxt_w   = acc_q + mcand_q * PROD_W'(mplier_q[BITS_PER_STEP-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      neg_q      <= 1'b0;
      wide_run_q <= 1'b0;
      wide_q     <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      mcand_q    <= '0;
      mplier_q   <= '0;
      prod_q     <= '0;
    end else if (accept_w) begin
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      cnt_q      <= CNT_W'(STEPS);
      acc_q      <= '0;
      mcand_q    <= {{WORD_W{1'b0}}, magnitude(opa_i, signed_i)};
      mplier_q   <= magnitude(opb_i, signed_i);
      neg_q      <= signed_i && (opa_i[WORD_W-1] ^ opb_i[WORD_W-1]);
      wide_run_q <= wide_i;
    end else if (busy_q) begin
      acc_q    <= acc_nxt_w;
      mcand_q  <= mcand_q << BITS_PER_STEP;
      mplier_q <= mplier_q >> BITS_PER_STEP;
      cnt_q    <= cnt_q - CNT_W'(1);
      if (last_step_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        prod_q <= neg_q ? (~acc_nxt_w + 1'b1) : acc_nxt_w;
        wide_q <= wide_run_q;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign wide_o = wide_q;
  assign prod_o = prod_q;

  // checker counter: cycles spent since the accepting edge
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (accept_w) lat_q <= '0;
    else if (busy_q)   lat_q <= lat_q + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lat_q == (CNT_W+1)'(STEPS))) else $error("latency off"); // R8
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step_w) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1))) else $error("restart while busy"); // R9
endmodule

// File: rtl/mpy_unit.sv
`timescale 1ns/1ps
module mpy_unit
  import mpy_pkg::*;
#(
  parameter int BITS_PER_STEP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         op_i,
  input  logic [31:0]        src_a_i,
  input  logic [31:0]        src_b_i,
  input  logic [15:0]        imm_i,
  output logic [31:0]        res_lo_o,
  output logic [31:0]        res_hi_o,
  output logic               hi_we_o,
  output logic               done_o
);
  logic [WORD_W-1:0]   opa_w, opb_w;
  logic                sgn_w, wide_w, busy_w, core_done_w, core_wide_w;
  logic [2*WORD_W-1:0] prod_w;

  mpy_opfmt u_fmt (
    .op_i     (mpy_op_e'(op_i)),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .imm_i    (imm_i),
    .opa_o    (opa_w),
    .opb_o    (opb_w),
    .signed_o (sgn_w),
    .wide_o   (wide_w)
  );

  mpy_core #(.BITS_PER_STEP(BITS_PER_STEP)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_i),
    .opa_i    (opa_w),
    .opb_i    (opb_w),
    .signed_i (sgn_w),
    .wide_i   (wide_w),
    .busy_o   (busy_w),
    .done_o   (core_done_w),
    .wide_o   (core_wide_w),
    .prod_o   (prod_w)
  );

  assign res_lo_o = prod_w[WORD_W-1:0];
  assign res_hi_o = core_wide_w ? prod_w[2*WORD_W-1:WORD_W] : '0;
  assign hi_we_o  = core_done_w && core_wide_w;
  assign done_o   = core_done_w;

  AST_HI_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we_o |-> done_o) else $error("high write outside done"); // R1
  AST_HALF_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !hi_we_o) |-> (res_hi_o == '0)) else $error("high word not clear"); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(res_lo_o) && $stable(res_hi_o))) else $error("result moved"); // R8
  AST_HALF_OPERAND_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_w && !wide_w && sgn_w) |-> (opa_w[WORD_W-1:HALF_W] == {HALF_W{opa_w[HALF_W-1]}})) else $error("half operand"); // R5
endmodule

// File: tb/mpy_unit_bench.sv
`timescale 1ns/1ps
module mpy_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BPS   = 4;
  localparam int STEPS = 32 / BPS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] sa = '0, sb = '0;
  logic [15:0] imm = '0;
  logic [31:0] res_lo, res_hi;
  logic hi_we, done;

  mpy_unit #(.BITS_PER_STEP(BPS)) u_mpy_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .src_a_i(sa), .src_b_i(sb), .imm_i(imm),
    .res_lo_o(res_lo), .res_hi_o(res_hi), .hi_we_o(hi_we), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: returns {we, hi, lo}
  function automatic logic [64:0] ref_mul(input logic [2:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im);
    int s9, s5, x, y;
    longint p;
    logic [63:0] u;
    logic [31:0] w9;
    s9 = im[8] ? int'(im[8:0]) - 512 : int'(im[8:0]);
    s5 = im[4] ? int'(im[4:0]) - 32  : int'(im[4:0]);
    w9 = 32'(s9);
    case (o)
      3'd0: begin p = longint'($signed(b)) * longint'($signed(a)); return {1'b1, 64'(p)}; end
      3'd1: begin p = longint'($signed(b)) * longint'(s9);         return {1'b1, 64'(p)}; end
      3'd2: begin u = {32'd0, b} * {32'd0, a};                      return {1'b1, u}; end
      3'd3: begin u = {32'd0, b} * {32'd0, w9};                     return {1'b1, u}; end
      3'd4: begin x = int'($signed(b[15:0])); y = int'($signed(a[15:0])); return {33'd0, 32'(x*y)}; end
      3'd5: begin x = int'($signed(b[15:0])); return {33'd0, 32'(x*s5)}; end
      3'd6: begin x = int'($signed(a[15:0])); y = int'($signed(im)); return {33'd0, 32'(x*y)}; end
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R10";
    endcase
  endfunction

  // model state
  int          m_cnt = 0;
  bit          m_done = 0;
  logic [64:0] m_pend = '0, m_out = '0;
  string       m_tag = "R11", m_pend_tag = "R11";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_out = '0; m_tag = "R11";
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_out = m_pend; m_tag = m_pend_tag;
        end
      end else if (start) begin
        m_pend = ref_mul(op, sa, sb, imm);
        m_pend_tag = tag_of(op);
        m_cnt = STEPS;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(done == m_done, "R8 done", 64'(done), 64'(m_done));
      check(res_lo == m_out[31:0], m_tag, 64'(res_lo), 64'(m_out[31:0]));
      check(res_hi == (m_out[64] ? m_out[63:32] : 32'd0), m_tag, 64'(res_hi), 64'(m_out[63:32]));
      check(hi_we == (m_done && m_out[64]), m_tag, 64'(hi_we), 64'(m_done && m_out[64]));
    end
  end

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    @(negedge clk);
    op = o; sa = a; sb = b; imm = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (STEPS + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(res_lo == 0 && res_hi == 0 && !done && !hi_we, "R11", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    // R1 signed word corners
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0);
    issue(3'd0, 32'hFFFF_FFFF, 32'h0000_0007, 16'h0);
    issue(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0);
    // R2 signed word immediate
    issue(3'd1, 32'h0, 32'h0001_0000, 16'h0100);
    issue(3'd1, 32'h0, 32'hFFFF_FFFD, 16'hFE00 | 16'h00FF);
    // R3 unsigned word
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    issue(3'd2, 32'h8000_0001, 32'h0000_0003, 16'h0);
    // R4 unsigned word with sign-extended immediate
    issue(3'd3, 32'h0, 32'h0000_0002, 16'h01FF);
    issue(3'd3, 32'h0, 32'hFFFF_FFFF, 16'h0100);
    // R5 halfword register, upper source bits are garbage
    issue(3'd4, 32'hDEAD_8000, 32'hBEEF_8000, 16'h0);
    issue(3'd4, 32'h1234_FFFF, 32'hFFFF_0005, 16'h0);
    // R6 short immediate
    issue(3'd5, 32'h0, 32'hAAAA_7FFF, 16'hFFF0);
    issue(3'd5, 32'h0, 32'h0000_0003, 16'h000F);
    // R7 16-bit immediate, src_b ignored
    issue(3'd6, 32'h5555_8000, 32'hFFFF_FFFF, 16'h8000);
    issue(3'd6, 32'h0000_0100, 32'h1234_5678, 16'h7FFF);
    // R10 reserved code
    issue(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    // R9: start pulses during a run are ignored
    @(negedge clk);
    op = 3'd0; sa = 32'h0000_0011; sb = 32'h0000_0013; imm = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 3'd2; sa = 32'hFFFF_FFFF; sb = 32'h0000_0009; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (STEPS) @(negedge clk);
    check(res_lo == 32'd323 && res_hi == 32'd0, "R9", {res_hi, res_lo}, 64'd323);
    // R9/R8: start held high restarts in the done cycle
    @(negedge clk);
    op = 3'd5; sa = 0; sb = 32'h0000_0064; imm = 16'h001D; start = 1'b1;
    repeat (3 * (STEPS + 1)) @(negedge clk);
    start = 1'b0;
    repeat (STEPS + 2) @(negedge clk);
    // mixed random traffic
    for (int i = 0; i < 60; i++) issue(3'($urandom), $urandom, $urandom, 16'($urandom));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule